// File: doc/BRIEF.md
# Timestamp Event and Interrupt Unit

This block sits beside a free-running 64-bit nanosecond time counter. It turns the timer's event sources into one interrupt request. The sources are two alarm-match strobes, three periodic-pulse strobes and two asynchronous external trigger inputs. All of them come from neighbouring logic. Each source sets a sticky bit in an event register. A mask register enables bits onto a single level-sensitive interrupt line. Software acknowledges a bit by writing a one to it.

Each trigger input passes through a two-flop synchronizer and then an edge detector. A per-trigger control bit selects whether the rising or the falling edge is active. On an active edge the block copies the current 64-bit time into a high/low register pair for that trigger and raises the trigger's event bit. All state is reached through a 32-bit word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `tsu_event_irq`

## Requirements
- R1: After reset the control, event, mask and all capture registers read zero and `irq` is low.
- R2: A one-cycle strobe sets an event bit on the next clock edge. The bit positions are: alarm 0 at bit 16, alarm 1 at bit 17, pulse 0 at bit 7, pulse 1 at bit 6, pulse 2 at bit 5, trigger 0 capture at bit 24, trigger 1 capture at bit 25.
- R3: Writing to the event register (address 1) clears every bit written as one. Bits written as zero keep their value.
- R4: `irq` is high exactly when some event bit is set and its mask bit is set. A pending bit that is masked off does not raise `irq`.
- R5: The mask register (address 2) uses the event bit positions. Only bits 25, 24, 17, 16, 7, 6 and 5 are stored, so writing all ones reads back 0x030300E0.
- R6: Control bit 8 selects the active edge of trigger 0 and bit 9 that of trigger 1 (0 = rising, 1 = falling). An edge of the other direction sets no event and leaves the capture registers unchanged.
- R7: On an active trigger edge, the time present on `time_ns` at the capturing clock edge is stored. Trigger 0 stores the upper word at address 3 and the lower word at address 4. Trigger 1 uses addresses 5 and 6.
- R8: A trigger level change applied before clock edge E0 is recorded at edge E2, the third rising edge. The event bit is still clear after E1.
- R9: An active edge that arrives while the trigger's event bit is still set overwrites the capture registers, and the event bit stays set.
- R10: When a hardware set and a software clear of the same event bit fall in the same cycle, the bit ends up set.
- R11: The control register (address 0) reads back only bits 9:8. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| time_ns | input | 64 | Current time from the timer counter |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| alarm_hit | input | 2 | One-cycle alarm-match strobes |
| pulse_hit | input | 3 | One-cycle periodic-pulse strobes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the three-cycle trigger latency. A design that samples the raw input or drops a synchronizer stage would show the event one edge early. It drives the inactive edge under each polarity setting, so a detector that fires on both edges sets a spurious bit and overwrites the captured time. It collides a hardware set with a write-one clear, where a clear-wins design loses the event. It retriggers a channel whose bit is still pending, where a design that blocks capture while the bit is set keeps the stale time. A long random run of strobes, mask writes and partial acknowledges compares the event register and `irq` against a bench model, to catch wrong bit positions and clears that spill onto bits written as zero.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int DW = 32;
  localparam int TW = 64;
  localparam int AW = 3;

  localparam int TRIG_EV_LSB = 24;
  localparam int ALM_EV_LSB  = 16;
  localparam int PPS_EV_MSB  = 7;
  localparam int POL_LSB     = 8;
  localparam int CAP_BASE    = 3;

  typedef enum logic [AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_EVENT = 3'd1,
    RA_MASK  = 3'd2
  } reg_addr_e;

  function automatic logic [DW-1:0] impl_bits(input int ntrig, input int nalm, input int npps);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < ntrig; i++) m[TRIG_EV_LSB+i] = 1'b1;
    for (int i = 0; i < nalm; i++)  m[ALM_EV_LSB+i]  = 1'b1;
    for (int i = 0; i < npps; i++)  m[PPS_EV_MSB-i]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tsu_trig_capture.sv
module tsu_trig_capture #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_async,
  input  logic          fall_sel,
  input  logic [TW-1:0] time_ns,
  output logic          cap_stb,
  output logic [TW-1:0] cap_time
);
  logic          s1_q, s2_q, prev_q;
  logic [TW-1:0] cap_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig_async;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // Active edge seen on the synchronized level
  assign cap_stb = fall_sel ? (prev_q & ~s2_q) : (s2_q & ~prev_q);

  always_comb begin
    cap_n = cap_time;
    if (cap_stb) cap_n = time_ns;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_time <= '0;
    else        cap_time <= cap_n;
  end
endmodule

// File: rtl/tsu_event_bank.sv
module tsu_event_bank #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] ev_q,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  logic [DW-1:0] ev_n, mask_n, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_vec : '0;
    // hardware set applied after the clear so it wins
    ev_n    = ((ev_q & ~clr_eff) | set_vec) & IMPL;
    mask_n  = mask_we ? (mask_wdata & IMPL) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q   <= ev_n;
      mask_q <= mask_n;
    end
  end

  assign irq = |(ev_q & mask_q);
endmodule

// File: rtl/tsu_event_irq.sv
module tsu_event_irq
  import tsu_pkg::*;
#(
  parameter int NTRIG = 2,
  parameter int NALM  = 2,
  parameter int NPPS  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        time_ns,
  input  logic [NTRIG-1:0]     trig_in,
  input  logic [NALM-1:0]      alarm_hit,
  input  logic [NPPS-1:0]      pulse_hit,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq
);
  localparam logic [DW-1:0] IMPL = impl_bits(NTRIG, NALM, NPPS);

  logic [NTRIG-1:0]           pol_q, pol_n;
  logic [NTRIG-1:0]           cap_stb;
  logic [NTRIG-1:0][TW-1:0]   cap_time;
  logic [DW-1:0]              set_vec, ev_vec, mask_vec;
  logic                       ctrl_we, ev_we, mask_we;

  assign ctrl_we = reg_we && (reg_addr == RA_CTRL);
  assign ev_we   = reg_we && (reg_addr == RA_EVENT);
  assign mask_we = reg_we && (reg_addr == RA_MASK);

  always_comb begin
    pol_n = pol_q;
    if (ctrl_we) pol_n = reg_wdata[POL_LSB +: NTRIG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else        pol_q <= pol_n;
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    tsu_trig_capture #(.TW(TW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (trig_in[g]),
      .fall_sel   (pol_q[g]),
      .time_ns    (time_ns),
      .cap_stb    (cap_stb[g]),
      .cap_time   (cap_time[g])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NTRIG; i++) set_vec[TRIG_EV_LSB+i] = cap_stb[i];
    for (int i = 0; i < NALM; i++)  set_vec[ALM_EV_LSB+i]  = alarm_hit[i];
    for (int i = 0; i < NPPS; i++)  set_vec[PPS_EV_MSB-i]  = pulse_hit[i];
  end

  tsu_event_bank #(.DW(DW), .IMPL(IMPL)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_we     (ev_we),
    .clr_vec    (reg_wdata),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .ev_q       (ev_vec),
    .mask_q     (mask_vec),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata[POL_LSB +: NTRIG] = pol_q;
      RA_EVENT: reg_rdata = ev_vec;
      RA_MASK:  reg_rdata = mask_vec;
      default:  reg_rdata = '0;
    endcase
    for (int i = 0; i < NTRIG; i++) begin
      if (reg_addr == AW'(CAP_BASE + 2*i))     reg_rdata = cap_time[i][TW-1:DW];
      if (reg_addr == AW'(CAP_BASE + 2*i + 1)) reg_rdata = cap_time[i][DW-1:0];
    end
  end
endmodule

// File: rtl/tsu_event_irq_chk.sv
module tsu_event_irq_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      time_ns,
  input logic [1:0]       alarm_hit,
  input logic [2:0]       pulse_hit,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq,
  input logic [31:0]      ev_vec,
  input logic [31:0]      mask_vec,
  input logic [1:0]       cap_stb,
  input logic [1:0][63:0] cap_time
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[0] |=> ev_vec[16]); // R10

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && reg_wdata[16] && !alarm_hit[0]) |=> !ev_vec[16]); // R3

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && reg_wdata == 32'd0 && alarm_hit == 2'd0 &&
     pulse_hit == 3'd0 && cap_stb == 2'd0) |=> $stable(ev_vec)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == 32'd0) |-> !irq); // R4

  AST_CAP0_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb[0] |=> (ev_vec[24] && cap_time[0] == $past(time_ns))); // R7

  AST_CAP1_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb[1] |=> (ev_vec[25] && cap_time[1] == $past(time_ns))); // R7
endmodule

bind tsu_event_irq tsu_event_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .time_ns   (time_ns),
  .alarm_hit (alarm_hit),
  .pulse_hit (pulse_hit),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .ev_vec    (ev_vec),
  .mask_vec  (mask_vec),
  .cap_stb   (cap_stb),
  .cap_time  (cap_time)
);

// File: tb/tb_tsu_event_irq.sv
module tb_tsu_event_irq;
  localparam logic [31:0] IMPL = 32'h0303_00E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_ns = '0;
  logic [1:0]  trig_in = '0;
  logic [1:0]  alarm_hit = '0;
  logic [2:0]  pulse_hit = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tsu_event_irq dut (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .trig_in(trig_in),
    .alarm_hit(alarm_hit), .pulse_hit(pulse_hit), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] hw_bits(input logic [1:0] al, input logic [2:0] pp);
    logic [31:0] v = '0;
    v[16] = al[0]; v[17] = al[1];
    v[7] = pp[0]; v[6] = pp[1]; v[5] = pp[2];
    return v;
  endfunction

  // strobe source k for one cycle: 0..1 alarms, 2..4 pulses
  task automatic strobe(input int k);
    if (k < 2) alarm_hit[k] = 1'b1; else pulse_hit[k-2] = 1'b1;
    @(posedge clk); @(negedge clk);
    alarm_hit = '0; pulse_hit = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ev_m, mk_m, wd, setv;
    logic [1:0] al; logic [2:0] pp;
    int act;
    void'($urandom(32'h5EED_0042));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], d); check("R1 reset readback", d, 0);
    end
    check("R1 irq after reset", irq, 0);

    // R11 control readback and empty address
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R11 ctrl readback", d, 32'h0000_0300);
    wr(3'd0, 32'h0); rd(3'd7, d); check("R11 address 7", d, 0);

    // R5 mask positions
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R5 mask readback", d, IMPL);
    wr(3'd2, 32'h0);

    // R2 source positions, R3 write-one clear
    for (int k = 0; k < 5; k++) begin
      logic [31:0] e;
      e = (k < 2) ? hw_bits(2'(1 << k), 3'b0) : hw_bits(2'b0, 3'(1 << (k-2)));
      strobe(k);
      rd(3'd1, d); check("R2 event bit position", d, e);
      wr(3'd1, 32'h0); rd(3'd1, d); check("R3 zero write keeps", d, e);
      wr(3'd1, e); rd(3'd1, d); check("R3 write one clears", d, 0);
    end

    // R4 masking
    strobe(0);
    check("R4 masked event no irq", irq, 0);
    wr(3'd2, 32'h0000_0040); check("R4 other mask bit no irq", irq, 0);
    wr(3'd2, 32'h0001_0000); check("R4 enabled event irq", irq, 1);
    wr(3'd1, 32'h0001_0000); check("R4 irq drops on clear", irq, 0);
    wr(3'd2, 32'h0);

    // R8 latency, R7 capture, trigger 0 rising
    time_ns = 64'h0123_4567_89AB_CDEF;
    trig_in[0] = 1'b1;
    tick(2); rd(3'd1, d); check("R8 not yet after two edges", d, 0);
    tick(1); rd(3'd1, d); check("R8 event on third edge", d, 32'h0100_0000);
    rd(3'd3, d); check("R7 trig0 high word", d, 32'h0123_4567);
    rd(3'd4, d); check("R7 trig0 low word", d, 32'h89AB_CDEF);
    wr(3'd1, 32'h0100_0000);

    // R6 falling edge ignored under rising polarity
    time_ns = 64'hAAAA_0000_BBBB_0000;
    trig_in[0] = 1'b0; tick(5);
    rd(3'd1, d); check("R6 wrong edge no event", d, 0);
    rd(3'd4, d); check("R6 wrong edge keeps capture", d, 32'h89AB_CDEF);

    // R9 retrigger while pending
    trig_in[0] = 1'b1; tick(4);
    trig_in[0] = 1'b0; tick(4);
    time_ns = 64'h0000_0777_0000_0999;
    trig_in[0] = 1'b1; tick(4);
    rd(3'd1, d); check("R9 event stays set", d, 32'h0100_0000);
    rd(3'd3, d); check("R9 high overwritten", d, 32'h0000_0777);
    rd(3'd4, d); check("R9 low overwritten", d, 32'h0000_0999);
    wr(3'd1, 32'hFFFF_FFFF);

    // R6 / R7 trigger 1 falling polarity
    wr(3'd0, 32'h0000_0200);
    time_ns = 64'h1111_2222_3333_4444;
    trig_in[1] = 1'b1; tick(5);
    rd(3'd1, d); check("R6 rising ignored on falling select", d, 0);
    time_ns = 64'hFEDC_BA98_7654_3210;
    trig_in[1] = 1'b0; tick(3);
    rd(3'd1, d); check("R6 falling edge captured", d, 32'h0200_0000);
    rd(3'd5, d); check("R7 trig1 high word", d, 32'hFEDC_BA98);
    rd(3'd6, d); check("R7 trig1 low word", d, 32'h7654_3210);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, 32'h0);

    // R10 set beats clear
    alarm_hit = 2'b10; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0002_0000;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; alarm_hit = '0;
    rd(3'd1, d); check("R10 set wins over clear", d, 32'h0002_0000);
    wr(3'd1, 32'h0002_0000); rd(3'd1, d); check("R3 clear after collision", d, 0);

    // random phase: R2 R3 R4 R5 R10
    ev_m = '0; mk_m = '0;
    for (int it = 0; it < 400; it++) begin
      reg_we = 1'b0; alarm_hit = '0; pulse_hit = '0;
      rd(3'd1, d); check("R3 random event model", d, ev_m);
      check("R4 random irq model", irq, |(ev_m & mk_m));
      al = ($urandom % 3 == 0) ? 2'($urandom) : 2'b0;
      pp = ($urandom % 3 == 0) ? 3'($urandom) : 3'b0;
      setv = hw_bits(al, pp);
      act = $urandom % 4;
      wd = $urandom;
      alarm_hit = al; pulse_hit = pp;
      if (act == 0) begin
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = wd;
        ev_m = ev_m & ~wd;
      end else if (act == 1) begin
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = wd;
        mk_m = wd & IMPL;
      end
      ev_m = (ev_m | setv) & IMPL;
      @(posedge clk); @(negedge clk);
    end
    reg_we = 1'b0; alarm_hit = '0; pulse_hit = '0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule